// File: doc/BRIEF.md
# Four-Format Instruction Decoder

This block turns 16-bit instruction words into the control strobes and fields that a small register machine needs. The top two bits of each word select its format. The next four bits are the opcode. The decoder takes out register indexes and the signed PC-relative offset, sorts each operation into an ALU, memory, move, branch, trap or supervisor-swap class, and applies the privilege and legality checks.

The fetch side offers one word per cycle on `valid_i`, together with the current privilege level on `sup_mode_i`. The decoded result appears in registers one cycle after the word is accepted, and `dec_valid_o` marks it with a one-cycle pulse. The register-plus-immediate format takes two words. The decoder keeps the first word, raises `imm_wait_o`, and takes the next accepted word as raw 16-bit data and does not decode it. Cycles where `valid_i` is low are ignored, including while the decoder waits for the immediate word.

Top module: `instr_decoder`

## Requirements
- R1: After reset `dec_valid_o` and `imm_wait_o` are low. The format comes from bits 15:14 (00 short immediate, 01 register plus next-word immediate, 10 register-to-register, 11 no-operand) and the opcode from bits 13:10. `reg_a_o` is bits 9:5 in formats 10 and 01, bits 4:0 in format 11, and 0 in format 00. `reg_b_o` is bits 4:0 in format 10 and 0 in formats 00 and 11. `imm_o` is 0 except on the load-immediate result.
- R2: Format 10 opcodes 0 to 11 are the ALU operations, in this order: AND, OR, NOT, shift-left, shift-right, shift-left-through-carry, shift-right-through-carry, rotate-left, rotate-right, rotate-left-through-carry, rotate-right-through-carry, ADD. For these, `alu_op_o` is the opcode plus 1, and `reg_wr_o` and `flag_we_o` are both set. In every other case `alu_op_o` is 0 and `flag_we_o` is low.
- R3: Format 10 opcode 12 gives `load_o` with `reg_wr_o`, opcode 13 gives `store_o` with no register write, and opcode 14 gives `move_o` with `reg_wr_o`. At most one class strobe (load, store, move, load-immediate, branch, syscall, swap) is high in any result.
- R4: Format 01 opcode 0 produces no result when it is accepted. `imm_wait_o` is high from the next cycle until the immediate word is accepted. That word's result has `load_imm_o` and `reg_wr_o` set, `imm_o` equal to the word, `reg_b_o` equal to bits 9:5 of the first word, and `reg_a_o` equal to 0.
- R5: Format 00 opcode 0 is a relative branch and opcode 1 is the same branch taken only on carry (`br_carry_o`). For both, `pc_off_o` is bits 9:0 sign-extended to 16 bits. In every other format `pc_off_o` is 0.
- R6: Format 11 opcode 0 gives `syscall_o`. Opcode 1 is a register-absolute jump (`branch_o`, `br_abs_o`, `br_reg_o`). Opcode 2 is the same jump with `br_user_o` set. Opcode 3 is a register-relative jump (`branch_o`, `br_reg_o`).
- R7: Format 10 opcode 15 is the supervisor swap. It gives `swap_o` with `reg_wr_o` only when `sup_mode_i` was high with the word and `reg_a_o` is 4 or lower. Otherwise it is illegal.
- R8: Every unassigned opcode (format 01 opcodes 1 to 15, format 00 opcodes 2 to 15, format 11 opcodes 4 to 15) and every refused swap gives a result with `illegal_o` set and all strobes low. A format 01 word that is not opcode 0 does not start a wait for an immediate word.
- R9: Each accepted word that is not the first word of a two-word instruction produces exactly one result, one cycle later. Back-to-back words produce back-to-back results.
- R10: The immediate word is never decoded, even when its top bits form a valid or illegal instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction word offered this cycle |
| instr_i | input | 16 | Instruction or immediate word |
| sup_mode_i | input | 1 | Supervisor mode, sampled with the word |
| dec_valid_o | output | 1 | One-cycle pulse marking a decoded result |
| alu_op_o | output | 4 | ALU operation code (0 = none) |
| reg_a_o | output | 5 | Source register index / swap index |
| reg_b_o | output | 5 | Destination register index |
| imm_o | output | 16 | Immediate from the second word |
| pc_off_o | output | 16 | Sign-extended PC-relative offset |
| reg_wr_o | output | 1 | Destination register is written |
| flag_we_o | output | 1 | Zero and carry flags are updated |
| load_o | output | 1 | Memory load |
| store_o | output | 1 | Memory store |
| move_o | output | 1 | Register move |
| load_imm_o | output | 1 | Load of the immediate word |
| branch_o | output | 1 | Control transfer |
| br_carry_o | output | 1 | Branch taken only on carry |
| br_abs_o | output | 1 | Absolute branch target |
| br_user_o | output | 1 | Enter user mode on arrival |
| br_reg_o | output | 1 | Branch target from a register |
| syscall_o | output | 1 | Software exception |
| swap_o | output | 1 | Supervisor register swap |
| illegal_o | output | 1 | Illegal or privilege-violating instruction |
| imm_wait_o | output | 1 | Next accepted word is immediate data |

## Verification
The state most likely to be corrupted is the pending-immediate flag. If it is stuck, the next result shows up one accepted word early or late. A stray or missing `dec_valid_o` pulse, or an `imm_o` that holds a decoded word, then appears on the very next result. A wrong privilege or legality decision shows up in the same result as a swap or trap strobe that disagrees with `illegal_o`, one cycle after the word is accepted. The bench checks every result against a queue of expected results in order, so a single missing or extra pulse shifts every comparison that follows.

// File: rtl/idec_pkg.sv
package idec_pkg;
  localparam int unsigned INSTR_W = 16;
  localparam int unsigned ADDR_W  = 16;
  localparam int unsigned RIDX_W  = 5;
  localparam int unsigned OPC_W   = 4;
  localparam int unsigned OFF_W   = 10;

  typedef enum logic [1:0] {
    FMT_SIMM = 2'b00,
    FMT_RIMM = 2'b01,
    FMT_R2R  = 2'b10,
    FMT_NOP  = 2'b11
  } fmt_e;

  typedef enum logic [3:0] {
    ALU_NONE = 4'd0,  ALU_AND  = 4'd1,  ALU_OR   = 4'd2,  ALU_NOT  = 4'd3,
    ALU_SHL  = 4'd4,  ALU_SHR  = 4'd5,  ALU_SHLC = 4'd6,  ALU_SHRC = 4'd7,
    ALU_ROL  = 4'd8,  ALU_ROR  = 4'd9,  ALU_ROLC = 4'd10, ALU_RORC = 4'd11,
    ALU_ADD  = 4'd12
  } alu_op_e;

  typedef struct packed {
    alu_op_e alu;
    logic    reg_wr;
    logic    flag_we;
    logic    load;
    logic    store;
    logic    move;
    logic    load_imm;
    logic    branch;
    logic    br_carry;
    logic    br_abs;
    logic    br_user;
    logic    br_reg;
    logic    syscall;
    logic    swap;
    logic    illegal;
    logic    need_imm;
  } ctrl_t;
endpackage

// File: rtl/idec_fields.sv
module idec_fields
  import idec_pkg::*;
#(
  parameter int unsigned IW = INSTR_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned RW = RIDX_W,
  parameter int unsigned OW = OFF_W
) (
  input  logic [IW-1:0] instr_i,
  output fmt_e          fmt_o,
  output logic [3:0]    opc_o,
  output logic [RW-1:0] ra_o,
  output logic [RW-1:0] rb_o,
  output logic [AW-1:0] off_o
);
  localparam int unsigned OPC_LSB = IW - 2 - OPC_W;
  localparam int unsigned EXT_W   = AW - OW;

  logic [AW-1:0] sext;

  assign fmt_o = fmt_e'(instr_i[IW-1:IW-2]);
  assign opc_o = instr_i[IW-3:OPC_LSB];
  assign sext  = {{EXT_W{instr_i[OW-1]}}, instr_i[OW-1:0]};

  always_comb begin
    ra_o  = '0;
    rb_o  = '0;
    off_o = '0;
    unique case (fmt_o)
      FMT_R2R: begin
        ra_o = instr_i[2*RW-1:RW];
        rb_o = instr_i[RW-1:0];
      end
      FMT_RIMM: ra_o  = instr_i[2*RW-1:RW];
      FMT_NOP:  ra_o  = instr_i[RW-1:0];
      FMT_SIMM: off_o = sext;
      default: ;
    endcase
  end
endmodule

// File: rtl/idec_ctrl.sv
module idec_ctrl
  import idec_pkg::*;
#(
  parameter int unsigned RW       = RIDX_W,
  parameter int unsigned SREG_MAX = 4
) (
  input  fmt_e          fmt_i,
  input  logic [3:0]    opc_i,
  input  logic [RW-1:0] ra_i,
  input  logic          sup_i,
  output ctrl_t         ctrl_o
);
  localparam int unsigned LAST_ALU = 11;
  localparam logic [RW-1:0] SREG_LIM = RW'(SREG_MAX);

  always_comb begin
    ctrl_o     = '0;
    ctrl_o.alu = ALU_NONE;
    unique case (fmt_i)
      FMT_R2R: begin
        if (opc_i <= 4'(LAST_ALU)) begin
          ctrl_o.alu     = alu_op_e'(opc_i + 4'd1);
          ctrl_o.reg_wr  = 1'b1;
          ctrl_o.flag_we = 1'b1;
        end else begin
          unique case (opc_i)
            4'd12: begin ctrl_o.load = 1'b1; ctrl_o.reg_wr = 1'b1; end
            4'd13: ctrl_o.store = 1'b1;
            4'd14: begin ctrl_o.move = 1'b1; ctrl_o.reg_wr = 1'b1; end
            default: begin
              if (sup_i && (ra_i <= SREG_LIM)) begin
                ctrl_o.swap   = 1'b1;
                ctrl_o.reg_wr = 1'b1;
              end else begin
                ctrl_o.illegal = 1'b1;
              end
            end
          endcase
        end
      end
      FMT_RIMM: begin
        if (opc_i == 4'd0) ctrl_o.need_imm = 1'b1;
        else               ctrl_o.illegal  = 1'b1;
      end
      FMT_SIMM: begin
        unique case (opc_i)
          4'd0: ctrl_o.branch = 1'b1;
          4'd1: begin ctrl_o.branch = 1'b1; ctrl_o.br_carry = 1'b1; end
          default: ctrl_o.illegal = 1'b1;
        endcase
      end
      default: begin
        unique case (opc_i)
          4'd0: ctrl_o.syscall = 1'b1;
          4'd1: begin
            ctrl_o.branch = 1'b1; ctrl_o.br_abs = 1'b1; ctrl_o.br_reg = 1'b1;
          end
          4'd2: begin
            ctrl_o.branch = 1'b1; ctrl_o.br_abs = 1'b1; ctrl_o.br_reg = 1'b1;
            ctrl_o.br_user = 1'b1;
          end
          4'd3: begin ctrl_o.branch = 1'b1; ctrl_o.br_reg = 1'b1; end
          default: ctrl_o.illegal = 1'b1;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import idec_pkg::*;
#(
  parameter int unsigned IW       = INSTR_W,
  parameter int unsigned AW       = ADDR_W,
  parameter int unsigned RW       = RIDX_W,
  parameter int unsigned OW       = OFF_W,
  parameter int unsigned SREG_MAX = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [IW-1:0] instr_i,
  input  logic          sup_mode_i,
  output logic          dec_valid_o,
  output logic [3:0]    alu_op_o,
  output logic [RW-1:0] reg_a_o,
  output logic [RW-1:0] reg_b_o,
  output logic [IW-1:0] imm_o,
  output logic [AW-1:0] pc_off_o,
  output logic          reg_wr_o,
  output logic          flag_we_o,
  output logic          load_o,
  output logic          store_o,
  output logic          move_o,
  output logic          load_imm_o,
  output logic          branch_o,
  output logic          br_carry_o,
  output logic          br_abs_o,
  output logic          br_user_o,
  output logic          br_reg_o,
  output logic          syscall_o,
  output logic          swap_o,
  output logic          illegal_o,
  output logic          imm_wait_o
);
  fmt_e          f_fmt;
  logic [3:0]    f_opc;
  logic [RW-1:0] f_ra, f_rb;
  logic [AW-1:0] f_off;
  ctrl_t         dec_ctrl, ldi_ctrl, ctrl_q;

  logic          valid_q, wait_q;
  logic [RW-1:0] pend_q, ra_q, rb_q;
  logic [IW-1:0] imm_q;
  logic [AW-1:0] off_q;

  idec_fields #(.IW(IW), .AW(AW), .RW(RW), .OW(OW)) u_fields (
    .instr_i (instr_i),
    .fmt_o   (f_fmt),
    .opc_o   (f_opc),
    .ra_o    (f_ra),
    .rb_o    (f_rb),
    .off_o   (f_off)
  );

  idec_ctrl #(.RW(RW), .SREG_MAX(SREG_MAX)) u_ctrl (
    .fmt_i  (f_fmt),
    .opc_i  (f_opc),
    .ra_i   (f_ra),
    .sup_i  (sup_mode_i),
    .ctrl_o (dec_ctrl)
  );

  always_comb begin
    ldi_ctrl          = '0;
    ldi_ctrl.alu      = ALU_NONE;
    ldi_ctrl.load_imm = 1'b1;
    ldi_ctrl.reg_wr   = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      wait_q  <= 1'b0;
      pend_q  <= '0;
      ctrl_q  <= '0;
      ra_q    <= '0;
      rb_q    <= '0;
      imm_q   <= '0;
      off_q   <= '0;
    end else begin
      valid_q <= 1'b0;
      if (valid_i) begin
        if (wait_q) begin
          // second word is raw data, never decoded
          wait_q  <= 1'b0;
          valid_q <= 1'b1;
          ctrl_q  <= ldi_ctrl;
          ra_q    <= '0;
          rb_q    <= pend_q;
          imm_q   <= instr_i;
          off_q   <= '0;
        end else if (dec_ctrl.need_imm) begin
          wait_q <= 1'b1;
          pend_q <= f_ra;
        end else begin
          valid_q <= 1'b1;
          ctrl_q  <= dec_ctrl;
          ra_q    <= f_ra;
          rb_q    <= f_rb;
          imm_q   <= '0;
          off_q   <= f_off;
        end
      end
    end
  end

  assign dec_valid_o = valid_q;
  assign imm_wait_o  = wait_q;
  assign alu_op_o    = ctrl_q.alu;
  assign reg_a_o     = ra_q;
  assign reg_b_o     = rb_q;
  assign imm_o       = imm_q;
  assign pc_off_o    = off_q;
  assign reg_wr_o    = ctrl_q.reg_wr;
  assign flag_we_o   = ctrl_q.flag_we;
  assign load_o      = ctrl_q.load;
  assign store_o     = ctrl_q.store;
  assign move_o      = ctrl_q.move;
  assign load_imm_o  = ctrl_q.load_imm;
  assign branch_o    = ctrl_q.branch;
  assign br_carry_o  = ctrl_q.br_carry;
  assign br_abs_o    = ctrl_q.br_abs;
  assign br_user_o   = ctrl_q.br_user;
  assign br_reg_o    = ctrl_q.br_reg;
  assign syscall_o   = ctrl_q.syscall;
  assign swap_o      = ctrl_q.swap;
  assign illegal_o   = ctrl_q.illegal;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
  parameter int unsigned RW       = 5,
  parameter int unsigned SREG_MAX = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          sup_mode_i,
  input logic          dec_valid_o,
  input logic [RW-1:0] reg_a_o,
  input logic          reg_wr_o,
  input logic          flag_we_o,
  input logic          load_o,
  input logic          store_o,
  input logic          move_o,
  input logic          load_imm_o,
  input logic          branch_o,
  input logic          br_carry_o,
  input logic          br_reg_o,
  input logic          syscall_o,
  input logic          swap_o,
  input logic          illegal_o,
  input logic          imm_wait_o
);
  logic [6:0] cls;
  assign cls = {load_o, store_o, move_o, load_imm_o, branch_o, syscall_o, swap_o};

  // R2
  flag_implies_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && flag_we_o) |-> reg_wr_o);

  // R3
  class_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $onehot0(cls));

  // R4
  wait_no_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_wait_o |-> !dec_valid_o);

  // R4
  ldi_after_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(imm_wait_o) |=> (imm_wait_o || (dec_valid_o && load_imm_o)) || !$past(valid_i));

  // R5
  carry_branch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && br_carry_o) |-> (branch_o && !br_reg_o));

  // R7
  swap_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !imm_wait_o) ##1 (dec_valid_o && swap_o) |-> ($past(sup_mode_i) && reg_a_o <= RW'(SREG_MAX)));

  // R8
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && illegal_o) |-> (cls == '0 && !reg_wr_o && !flag_we_o));

  // R9
  result_needs_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i) |=> !dec_valid_o);
endmodule

bind instr_decoder instr_decoder_chk #(.RW(RW), .SREG_MAX(SREG_MAX)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .sup_mode_i  (sup_mode_i),
  .dec_valid_o (dec_valid_o),
  .reg_a_o     (reg_a_o),
  .reg_wr_o    (reg_wr_o),
  .flag_we_o   (flag_we_o),
  .load_o      (load_o),
  .store_o     (store_o),
  .move_o      (move_o),
  .load_imm_o  (load_imm_o),
  .branch_o    (branch_o),
  .br_carry_o  (br_carry_o),
  .br_reg_o    (br_reg_o),
  .syscall_o   (syscall_o),
  .swap_o      (swap_o),
  .illegal_o   (illegal_o),
  .imm_wait_o  (imm_wait_o)
);

// File: tb/instr_decoder_bench.sv
module instr_decoder_bench;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned WDOG_LIMIT = 20000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic        sup_mode_i = 1'b0;
  logic        dec_valid_o;
  logic [3:0]  alu_op_o;
  logic [4:0]  reg_a_o, reg_b_o;
  logic [15:0] imm_o, pc_off_o;
  logic reg_wr_o, flag_we_o, load_o, store_o, move_o, load_imm_o, branch_o;
  logic br_carry_o, br_abs_o, br_user_o, br_reg_o, syscall_o, swap_o, illegal_o, imm_wait_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [59:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  instr_decoder u_instr_decoder (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .sup_mode_i(sup_mode_i), .dec_valid_o(dec_valid_o), .alu_op_o(alu_op_o),
    .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .imm_o(imm_o), .pc_off_o(pc_off_o),
    .reg_wr_o(reg_wr_o), .flag_we_o(flag_we_o), .load_o(load_o), .store_o(store_o),
    .move_o(move_o), .load_imm_o(load_imm_o), .branch_o(branch_o),
    .br_carry_o(br_carry_o), .br_abs_o(br_abs_o), .br_user_o(br_user_o),
    .br_reg_o(br_reg_o), .syscall_o(syscall_o), .swap_o(swap_o),
    .illegal_o(illegal_o), .imm_wait_o(imm_wait_o)
  );

  // packing: alu, ra, rb, imm, off, 14 flags
  function automatic logic [59:0] pack(input logic [3:0] alu, input logic [4:0] ra,
      input logic [4:0] rb, input logic [15:0] imm, input logic [15:0] off,
      input logic [13:0] fl);
    return {alu, ra, rb, imm, off, fl};
  endfunction

  // flag bit order: reg_wr flag_we load store move load_imm branch br_carry br_abs br_user br_reg syscall swap illegal
  function automatic logic [59:0] expect_of(input logic [15:0] w, input logic sup);
    logic [1:0]  fmt = w[15:14];
    logic [3:0]  op  = w[13:10];
    logic [4:0]  ra  = 5'd0, rb = 5'd0;
    logic [15:0] off = 16'd0;
    logic [3:0]  alu = 4'd0;
    logic [13:0] fl  = 14'b0;
    case (fmt)
      2'b10: begin
        ra = w[9:5]; rb = w[4:0];
        if (op <= 4'd11) begin alu = op + 4'd1; fl = 14'b11_0000_0000_0000; end
        else if (op == 4'd12) fl = 14'b10_1000_0000_0000;
        else if (op == 4'd13) fl = 14'b00_0100_0000_0000;
        else if (op == 4'd14) fl = 14'b10_0010_0000_0000;
        else if (sup && ra <= 5'd4) fl = 14'b10_0000_0000_0010;
        else fl = 14'b00_0000_0000_0001;
      end
      2'b01: begin ra = w[9:5]; fl = 14'b1; end
      2'b00: begin
        off = {{6{w[9]}}, w[9:0]};
        if (op == 4'd0) fl = 14'b00_0000_1000_0000;
        else if (op == 4'd1) fl = 14'b00_0000_1100_0000;
        else fl = 14'b1;
      end
      default: begin
        ra = w[4:0];
        case (op)
          4'd0: fl = 14'b00_0000_0000_0100;
          4'd1: fl = 14'b00_0000_1010_1000;
          4'd2: fl = 14'b00_0000_1011_1000;
          4'd3: fl = 14'b00_0000_1000_1000;
          default: fl = 14'b1;
        endcase
      end
    endcase
    return pack(alu, ra, rb, 16'd0, off, fl);
  endfunction

  task automatic drive(input logic [15:0] w, input logic sup);
    @(negedge clk_i);
    valid_i = 1'b1; instr_i = w; sup_mode_i = sup;
  endtask

  task automatic send(input logic [15:0] w, input logic sup, input string tag);
    drive(w, sup);
    exp_q.push_back(expect_of(w, sup));
    tag_q.push_back(tag);
  endtask

  task automatic send_ldi(input logic [15:0] w1, input logic [15:0] w2, input int gap, input string tag);
    drive(w1, 1'b0);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0; instr_i = 16'hFFFF;
      check_bit(imm_wait_o, 1'b1, "R4 wait raised");
    end
    drive(w2, 1'b1);
    exp_q.push_back(pack(4'd0, 5'd0, w1[9:5], w2, 16'd0, 14'b10_0001_0000_0000));
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      valid_i = 1'b0;
    end
  endtask

  task automatic check_bit(input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && dec_valid_o === 1'b1) begin
      logic [59:0] act;
      act = pack(alu_op_o, reg_a_o, reg_b_o, imm_o, pc_off_o,
                 {reg_wr_o, flag_we_o, load_o, store_o, move_o, load_imm_o, branch_o,
                  br_carry_o, br_abs_o, br_user_o, br_reg_o, syscall_o, swap_o, illegal_o});
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R9 unexpected result: actual %h expected none", act);
      end else begin
        logic [59:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, act, e);
        end
      end
    end
  end

  // watchdog
  always @(posedge clk_i) begin
    cyc++;
    if (!done && cyc > WDOG_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < %0d", cyc, WDOG_LIMIT);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check_bit(dec_valid_o, 1'b0, "R1 reset valid");
    check_bit(imm_wait_o, 1'b0, "R1 reset wait");
    rst_ni = 1'b1;
    idle(2);

    // R2 / R3: all register-to-register opcodes, back to back (R9)
    for (int op = 0; op < 15; op++)
      send({2'b10, 4'(op), 5'(op + 3), 5'(31 - op)}, op[0], "R2_R3 r2r");
    // R7 swap
    send({2'b10, 4'd15, 5'd4, 5'd9}, 1'b1, "R7 swap legal");
    send({2'b10, 4'd15, 5'd0, 5'd1}, 1'b1, "R7 swap idx0");
    send({2'b10, 4'd15, 5'd5, 5'd9}, 1'b1, "R7 swap idx5");
    send({2'b10, 4'd15, 5'd2, 5'd9}, 1'b0, "R7 swap user");
    idle(1);

    // R5 short immediate offsets
    send({2'b00, 4'd0, 10'h1FF}, 1'b0, "R5 max pos");
    send({2'b00, 4'd0, 10'h200}, 1'b0, "R5 min neg");
    send({2'b00, 4'd1, 10'h3FF}, 1'b0, "R5 carry -1");
    send({2'b00, 4'd1, 10'h000}, 1'b1, "R5 carry 0");
    send({2'b00, 4'd5, 10'h155}, 1'b1, "R8 simm illegal");

    // R6 no-operand
    for (int op = 0; op < 4; op++)
      send({2'b11, 4'(op), 5'd0, 5'(op + 7)}, 1'b0, "R6 nop fmt");
    send({2'b11, 4'd9, 10'd0}, 1'b1, "R8 nop illegal");
    send({2'b01, 4'd3, 5'd6, 5'd0}, 1'b1, "R8 rimm illegal");
    idle(1);
    check_bit(imm_wait_o, 1'b0, "R8 no wait on illegal rimm");

    // R4 / R10 load immediate
    send_ldi({2'b01, 4'd0, 5'd17, 5'd0}, 16'hC000, 0, "R10 imm looks like syscall");
    send_ldi({2'b01, 4'd0, 5'd3, 5'd0}, 16'h7A5C, 3, "R4 ldi with gap");
    send_ldi({2'b01, 4'd0, 5'd31, 5'd0}, {2'b01, 4'd0, 10'h3FF}, 1, "R10 imm looks like ldi");
    send({2'b10, 4'd11, 5'd1, 5'd2}, 1'b0, "R9 after ldi");
    idle(1);
    check_bit(imm_wait_o, 1'b0, "R4 wait cleared");
    idle(3);

    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R9 missing results: actual %0d left expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule